// File: doc/BRIEF.md
# Interrupt request acceptance controller

This block keeps one pending request flag for every interrupt source and decides, once per instruction, whether the processor core takes an interrupt. A single-cycle event pulse from a source, such as an external pin edge or a timer underflow, sets the flag for that source. The flag stays set until the request is granted or software clears it. The core raises an acceptance strobe at the point in each instruction where an interrupt may be taken. Only at that strobe does the block look at the pending flags, the per-source enable bits and the global disable flag.

When one or more requests are eligible at the strobe, the block grants the one with the lowest source index. In the strobe cycle it outputs a take pulse, the winning index and the address of that source's vector. In the same cycle it outputs a one-hot clear for the winner's flag and a command that sets the global disable flag in the core. Requests that lose arbitration stay latched and compete again at the next strobe. The bus cycles that push state and fetch the vector belong to the core.

Top module: `irq_accept_ctrl`

## Requirements
- R1: After reset all pending flags are 0. While no flag has been set, `take_o`, `clr_o`, `set_dis_o`, `win_idx_o` and `vec_addr_o` stay 0 even with the strobe high.
- R2: A 1 on bit i of `evt_i` at a clock edge sets pending flag i. The flag can take part in arbitration from the next cycle on. It stays set until it is granted or cleared by software.
- R3: A source is eligible only when its pending flag is 1, its bit in `en_i` is 1 and `dis_flag_i` is 0. A source that is not eligible is never granted.
- R4: A grant happens only in a cycle where `accept_i` is 1. `take_o` is a single-cycle pulse in that cycle. Holding the strobe high does not grant the same request a second time.
- R5: Among the eligible sources the lowest index wins (index 0 has the highest priority).
- R6: An eligible request that loses arbitration keeps its flag and is granted at a later strobe once nothing with a higher priority is eligible.
- R7: On a grant, `clr_o` is one-hot at bit `win_idx_o`, and the winner's pending flag reads 0 from the next cycle on.
- R8: `set_dis_o` is 1 in exactly the cycles where `take_o` is 1.
- R9: On a grant, `win_idx_o` is the winning index and `vec_addr_o` equals VEC_BASE minus 2 times that index, as a 16-bit value (default VEC_BASE 16'hFFFC). Both are 0 when there is no grant.
- R10: If an event for a source arrives in the same cycle its flag is cleared, by software or by a grant, the flag stays set.
- R11: A 1 on bit i of `sw_clr_i` clears pending flag i at the next clock edge, so source i is not granted afterwards unless a new event arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | N_SRC | Source event pulses, one bit per source |
| en_i | input | N_SRC | Per-source enable bits |
| dis_flag_i | input | 1 | Global interrupt disable flag from the core |
| accept_i | input | 1 | Acceptance strobe, once per instruction |
| sw_clr_i | input | N_SRC | Software clear mask for pending flags |
| take_o | output | 1 | Interrupt taken in this cycle |
| win_idx_o | output | IDX_W | Index of the granted source |
| vec_addr_o | output | VEC_W | Vector address of the granted source |
| clr_o | output | N_SRC | One-hot clear of the winner's flag |
| set_dis_o | output | 1 | Command to set the global disable flag |

## Verification
The properties assume that `evt_i`, `en_i`, `dis_flag_i`, `accept_i` and `sw_clr_i` change only between clock edges and are stable at each sampling edge. They also assume that `dis_flag_i` is driven from outside the block, so a grant does not have to be followed by a high disable flag. The bench changes every input at the falling edge and compares outputs one time unit later, before the next rising edge. It sets the disable input by hand to stand in for the core. The bench also treats an event as visible to arbitration only from the cycle after its pulse.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;
  function automatic logic [15:0] vec_of(input logic [15:0] base, input int unsigned idx);
    logic [15:0] off;
    off = 16'(idx << 1);
    return base - off;
  endfunction
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int N_SRC = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] evt_i,
  input  logic [N_SRC-1:0] sw_clr_i,
  input  logic [N_SRC-1:0] ack_clr_i,
  output logic [N_SRC-1:0] pend_o
);
  for (genvar i = 0; i < N_SRC; i++) begin : g_flag
    logic flag_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        flag_q <= 1'b0;
      else if (evt_i[i])                  flag_q <= 1'b1; // new event beats clear
      else if (sw_clr_i[i] || ack_clr_i[i]) flag_q <= 1'b0;
    end
    assign pend_o[i] = flag_q;
  end
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb #(
  parameter int N_SRC = 8,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0] req_i,
  output logic [N_SRC-1:0] gnt_o,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [N_SRC:0] higher;
  assign higher[0] = 1'b0;
  for (genvar i = 0; i < N_SRC; i++) begin : g_chain
    assign gnt_o[i]    = req_i[i] & ~higher[i];
    assign higher[i+1] = higher[i] | req_i[i];
  end
  assign any_o = higher[N_SRC];

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (gnt_o[i]) idx_o = idx_o | IDX_W'(i);
    end
  end
endmodule

// File: rtl/irq_vec_gen.sv
module irq_vec_gen #(
  parameter int          IDX_W    = 3,
  parameter int          VEC_W    = 16,
  parameter logic [15:0] VEC_BASE = 16'hFFFC
) (
  input  logic [IDX_W-1:0] idx_i,
  input  logic             valid_i,
  output logic [VEC_W-1:0] vec_o
);
  logic [15:0] raw;
  assign raw   = irq_accept_pkg::vec_of(VEC_BASE, int'(idx_i));
  assign vec_o = valid_i ? VEC_W'(raw) : '0;
endmodule

// File: rtl/irq_accept_ctrl.sv
module irq_accept_ctrl #(
  parameter int          N_SRC    = 8,
  parameter int          VEC_W    = 16,
  parameter logic [15:0] VEC_BASE = 16'hFFFC,
  localparam int         IDX_W    = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] evt_i,
  input  logic [N_SRC-1:0] en_i,
  input  logic             dis_flag_i,
  input  logic             accept_i,
  input  logic [N_SRC-1:0] sw_clr_i,
  output logic             take_o,
  output logic [IDX_W-1:0] win_idx_o,
  output logic [VEC_W-1:0] vec_addr_o,
  output logic [N_SRC-1:0] clr_o,
  output logic             set_dis_o
);
  logic [N_SRC-1:0] pend_q;
  logic [N_SRC-1:0] elig;
  logic [N_SRC-1:0] gnt;
  logic             any_elig;
  logic [IDX_W-1:0] arb_idx;

  irq_pend_bank #(.N_SRC(N_SRC)) u_pend (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .evt_i     (evt_i),
    .sw_clr_i  (sw_clr_i),
    .ack_clr_i (clr_o),
    .pend_o    (pend_q)
  );

  assign elig = pend_q & en_i & {N_SRC{~dis_flag_i}};

  irq_prio_arb #(.N_SRC(N_SRC)) u_arb (
    .req_i (elig),
    .gnt_o (gnt),
    .any_o (any_elig),
    .idx_o (arb_idx)
  );

  assign take_o    = accept_i & any_elig;
  assign clr_o     = take_o ? gnt : '0;
  assign set_dis_o = take_o;
  assign win_idx_o = take_o ? arb_idx : '0;

  irq_vec_gen #(.IDX_W(IDX_W), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE)) u_vec (
    .idx_i   (arb_idx),
    .valid_i (take_o),
    .vec_o   (vec_addr_o)
  );
endmodule

// File: rtl/irq_accept_chk.sv
module irq_accept_chk #(
  parameter int N_SRC = 8,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_SRC-1:0] evt_i,
  input logic [N_SRC-1:0] en_i,
  input logic             dis_flag_i,
  input logic             accept_i,
  input logic [N_SRC-1:0] sw_clr_i,
  input logic             take_o,
  input logic [IDX_W-1:0] win_idx_o,
  input logic [N_SRC-1:0] clr_o,
  input logic             set_dis_o,
  input logic [N_SRC-1:0] pend_q
);
  AST_EVT_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i != '0) |=> ((pend_q & $past(evt_i)) == $past(evt_i))); // R2
  AST_HOLD_NO_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_o |=> (($past(pend_q) & ~$past(sw_clr_i) & ~pend_q) == '0)); // R6
  AST_ELIGIBLE_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> (!dis_flag_i && ((clr_o & pend_q & en_i) == clr_o))); // R3
  AST_STROBE_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> accept_i); // R4
  AST_TOP_PRIORITY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> ((pend_q & en_i & (clr_o - 1'b1)) == '0)); // R5
  AST_CLR_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> ($countones(clr_o) == 1 && clr_o[win_idx_o])); // R7
  AST_NO_CLR_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_o |-> (clr_o == '0)); // R7
  AST_WIN_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && ((evt_i & clr_o) == '0)) |=> ((pend_q & $past(clr_o)) == '0)); // R7
  AST_DIS_WITH_TAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> set_dis_o); // R8
  AST_DIS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_o |-> !set_dis_o); // R8
endmodule

bind irq_accept_ctrl irq_accept_chk #(.N_SRC(N_SRC)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .evt_i      (evt_i),
  .en_i       (en_i),
  .dis_flag_i (dis_flag_i),
  .accept_i   (accept_i),
  .sw_clr_i   (sw_clr_i),
  .take_o     (take_o),
  .win_idx_o  (win_idx_o),
  .clr_o      (clr_o),
  .set_dis_o  (set_dis_o),
  .pend_q     (pend_q)
);

// File: tb/irq_accept_ctrl_tb.sv
`timescale 1ns/1ps
module irq_accept_ctrl_tb;
  localparam int N = 8;
  localparam logic [15:0] BASE = 16'hFFFC;
  localparam int NV = 17;

  typedef struct packed {
    logic [7:0] evt;
    logic [7:0] en;
    logic       dis;
    logic [7:0] clr;
    logic       acc;
    logic       exp_take;
    logic [2:0] exp_idx;
  } vec_t;

  localparam vec_t TBL [NV] = '{
    '{8'h00, 8'hFF, 1'b0, 8'h00, 1'b1, 1'b0, 3'd0}, // 0  R1 idle strobe
    '{8'h24, 8'hFF, 1'b0, 8'h00, 1'b0, 1'b0, 3'd0}, // 1  R2 events not yet visible
    '{8'h00, 8'hFF, 1'b0, 8'h00, 1'b0, 1'b0, 3'd0}, // 2  R4 pending, no strobe
    '{8'h00, 8'hFF, 1'b0, 8'h00, 1'b1, 1'b1, 3'd2}, // 3  R5 lowest index wins
    '{8'h00, 8'hFF, 1'b1, 8'h00, 1'b1, 1'b0, 3'd0}, // 4  R3 disable flag
    '{8'h00, 8'hDF, 1'b0, 8'h00, 1'b1, 1'b0, 3'd0}, // 5  R3 enable bit low
    '{8'h00, 8'hFF, 1'b0, 8'h00, 1'b1, 1'b1, 3'd5}, // 6  R6 loser still latched
    '{8'h00, 8'hFF, 1'b0, 8'h00, 1'b1, 1'b0, 3'd0}, // 7  R7 winner cleared
    '{8'h81, 8'hFF, 1'b0, 8'h00, 1'b0, 1'b0, 3'd0}, // 8  R2 set 0 and 7
    '{8'h00, 8'hFF, 1'b0, 8'h01, 1'b0, 1'b0, 3'd0}, // 9  R11 sw clear bit 0
    '{8'h00, 8'hFF, 1'b0, 8'h00, 1'b1, 1'b1, 3'd7}, // 10 R11 only 7 left
    '{8'h08, 8'hFF, 1'b0, 8'h08, 1'b0, 1'b0, 3'd0}, // 11 R10 event vs sw clear
    '{8'h08, 8'hFF, 1'b0, 8'h00, 1'b1, 1'b1, 3'd3}, // 12 R10 event vs grant
    '{8'h00, 8'hFF, 1'b0, 8'h00, 1'b1, 1'b1, 3'd3}, // 13 R10 flag survived
    '{8'h03, 8'hFF, 1'b0, 8'h00, 1'b0, 1'b0, 3'd0}, // 14 R2 set 0 and 1
    '{8'h00, 8'h02, 1'b0, 8'h00, 1'b1, 1'b1, 3'd1}, // 15 R3 masked 0, R9 idx 1
    '{8'h00, 8'hFF, 1'b0, 8'h00, 1'b1, 1'b1, 3'd0}  // 16 R6 R9 idx 0
  };
  localparam string REQ [NV] = '{"R1","R2","R4","R5","R3","R3","R6","R7","R2",
                                 "R11","R11","R10","R10","R10","R2","R3","R6"};

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [N-1:0] evt_i = '0, en_i = '0, sw_clr_i = '0;
  logic         dis_flag_i = 1'b0, accept_i = 1'b0;
  logic         take_o, set_dis_o;
  logic [2:0]   win_idx_o;
  logic [15:0]  vec_addr_o;
  logic [N-1:0] clr_o;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irq_accept_ctrl #(.N_SRC(N), .VEC_W(16), .VEC_BASE(BASE)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .evt_i(evt_i), .en_i(en_i),
    .dis_flag_i(dis_flag_i), .accept_i(accept_i), .sw_clr_i(sw_clr_i),
    .take_o(take_o), .win_idx_o(win_idx_o), .vec_addr_o(vec_addr_o),
    .clr_o(clr_o), .set_dis_o(set_dis_o)
  );

  task automatic check_out(input string req, input logic et, input logic [2:0] ei);
    logic [15:0] ev;
    logic [N-1:0] ec;
    ev = et ? BASE - 16'({13'd0, ei} << 1) : 16'h0;
    ec = et ? N'(1) << ei : '0;
    n_chk++;
    if (take_o !== et || set_dis_o !== et || win_idx_o !== (et ? ei : 3'd0) ||
        vec_addr_o !== ev || clr_o !== ec) begin
      n_bad++;
      $display("FAIL %s: take=%b dis=%b idx=%0d vec=%h clr=%h, expected take=%b dis=%b idx=%0d vec=%h clr=%h",
               req, take_o, set_dis_o, win_idx_o, vec_addr_o, clr_o,
               et, et, et ? ei : 3'd0, ev, ec);
    end
  endtask

  task automatic drive(input logic [7:0] ev, input logic [7:0] en, input logic d,
                       input logic [7:0] c, input logic a);
    @(negedge clk);
    evt_i = ev; en_i = en; dis_flag_i = d; sw_clr_i = c; accept_i = a;
    #1;
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    en_i = '1; accept_i = 1'b1; #1;
    check_out("R1", 1'b0, 3'd0); // outputs idle in reset
    @(negedge clk);
    rst_ni = 1'b1;

    for (int v = 0; v < NV; v++) begin
      drive(TBL[v].evt, TBL[v].en, TBL[v].dis, TBL[v].clr, TBL[v].acc);
      check_out(REQ[v], TBL[v].exp_take, TBL[v].exp_idx);
    end

    // R4: strobe held high two cycles, single pending request granted once
    drive(8'h10, 8'hFF, 1'b0, 8'h00, 1'b0);
    drive(8'h00, 8'hFF, 1'b0, 8'h00, 1'b1);
    check_out("R4", 1'b1, 3'd4);
    drive(8'h00, 8'hFF, 1'b0, 8'h00, 1'b1);
    check_out("R4", 1'b0, 3'd0);

    // R1: reset in mid-run drops pending flags
    drive(8'h40, 8'hFF, 1'b0, 8'h00, 1'b0);
    drive(8'h00, 8'hFF, 1'b0, 8'h00, 1'b0);
    rst_ni = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    drive(8'h00, 8'hFF, 1'b0, 8'h00, 1'b1);
    check_out("R1", 1'b0, 3'd0);

    // R6: disabled interval keeps all requests; R5 order afterwards
    drive(8'hC0, 8'hFF, 1'b0, 8'h00, 1'b0);
    drive(8'h00, 8'hFF, 1'b1, 8'h00, 1'b1);
    check_out("R6", 1'b0, 3'd0);
    drive(8'h00, 8'hFF, 1'b0, 8'h00, 1'b1);
    check_out("R5", 1'b1, 3'd6);
    drive(8'h00, 8'hFF, 1'b0, 8'h00, 1'b1);
    check_out("R9", 1'b1, 3'd7);

    drive(8'h00, 8'h00, 1'b0, 8'h00, 1'b0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule